// File: doc/BRIEF.md
# Pipelined no-turnaround synchronous SRAM

A small synchronous static memory that accepts a new read or write on every clock cycle in any mix, with no idle cycle on the data bus when the direction changes. Address and control are registered at the rising edge. Read data comes out of an output register one enabled edge after the address edge. Write data follows its address by two enabled edges, so a write's data occupies the same bus slot that a read issued in the same cycle would use. Until a write reaches the array it waits in internal pending stages, and reads that hit those stages are served from them lane by lane.

Each access either loads a fresh external address or advances a two-bit burst counter held from the last load. A static pin picks a linear or an interleaved beat order. Three chip selects qualify a load. Per-lane write strobes pick which 9-bit lanes a write changes. A clock-enable input freezes the whole machine. An asynchronous output enable and a sleep input gate the data-out enable without touching stored data. The data bus is split into separate input and output buses plus an output-enable line. Memory depth, lane count and lane width are parameters.

Top module: `noturn_sram`

## Requirements
- R1: On an enabled edge with adv=0, a load occurs. With sel_a_n=0, sel_b=1 and sel_c_n=0 all asserted, the load starts an access at addr: a write when wr_n=0 and a read when wr_n=1.
- R2: A read whose address is taken at enabled edge n drives its word on dq_out from enabled edge n+1 until the next enabled edge. dq_oe is high in that window when out_en_n=0 and sleep=0.
- R3: The data for a write whose address is taken at enabled edge n is sampled from dq_in at enabled edge n+2. Lane l (bits 9l+8 down to 9l) is written only when lane_wr_n[l]=0 on the address edge. All other lanes keep their old contents.
- R4: A read returns the effect of every earlier-issued write in issue order, including writes still pending and one whose data arrives on the same edge, merged lane by lane.
- R5: On an enabled edge with adv=1, the access continues the last loaded burst with the same operation. Its low two address bits for beat k are (start+k) mod 4 when burst_lin=1 and start XOR k when burst_lin=0. The upper bits stay fixed, and the counter keeps wrapping past four beats.
- R6: On advance cycles, wr_n and the three selects are ignored, while lane_wr_n is sampled on every beat.
- R7: A load with any select not asserted is a deselect. It does no array access, and advances after it also do none. Its result slot has dq_oe low.
- R8: After reset, and in the result slot of any write, dq_oe is low.
- R9: While clk_en_n=1, an edge changes nothing: dq_out, dq_oe, the burst counter, the pipeline and the pending writes all hold, and dq_in is not sampled.
- R10: out_en_n=1 drives dq_oe low at once, with no clock edge, and has no effect on stored data.
- R11: sleep=1 drives dq_oe low at once, and memory contents survive the sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en_n | input | 1 | Active-low clock enable; high suspends all state |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data bus |
| burst_lin | input | 1 | Static burst order: 1 linear, 0 interleaved |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous power-down, disables outputs |
| dq_out | output | LANES*LANE_W | Read data from the output register |
| dq_oe | output | 1 | Data-out drive enable |

## Verification
A read issued at one enabled edge is due on dq_out right after the next enabled edge. Write data must be on dq_in at the second enabled edge after its address. The bench keeps a two-slot pipeline of issued operations that shifts only on enabled slots, so it drives write data and checks read results exactly on those edges even when suspended slots are mixed in. All outputs are sampled at the falling edge. The asynchronous checks of out_en_n and sleep are taken a fraction of a cycle after the pin changes, before any clock edge.

// File: rtl/noturn_sram.sv
`timescale 1ns/1ps
module noturn_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dq_in,
  input  logic              burst_lin,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  logic go, sel_all;
  assign go      = !clk_en_n;
  assign sel_all = !sel_a_n && sel_b && !sel_c_n;

  logic              ctx_v, ctx_we;
  logic [ADDR_W-3:0] ctx_hi;
  logic [1:0]        ctx_lo, beat, nbeat, seq_lo;
  assign nbeat  = beat + 2'd1;
  assign seq_lo = burst_lin ? ctx_lo + nbeat : ctx_lo ^ nbeat;

  logic              cur_v, cur_we;
  logic [ADDR_W-1:0] cur_addr;
  assign cur_v    = adv ? ctx_v  : sel_all;
  assign cur_we   = adv ? ctx_we : !wr_n;
  assign cur_addr = adv ? {ctx_hi, seq_lo} : addr;

  logic              s1_v, s1_we, s2_v, s2_we, pend_v, rd_v;
  logic [ADDR_W-1:0] s1_addr, s2_addr, pend_addr;
  logic [LANES-1:0]  s1_be, s2_be, pend_be;
  logic [DW-1:0]     pend_data, out_q, rd_word;

  always_comb begin
    rd_word = mem[s1_addr];
    for (int l = 0; l < LANES; l++) begin
      if (pend_v && pend_addr == s1_addr && pend_be[l])
        rd_word[l*LANE_W +: LANE_W] = pend_data[l*LANE_W +: LANE_W];
      if (s2_v && s2_we && s2_addr == s1_addr && s2_be[l])
        rd_word[l*LANE_W +: LANE_W] = dq_in[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_v <= 1'b0; ctx_we <= 1'b0; ctx_hi <= '0; ctx_lo <= '0; beat <= '0;
      s1_v <= 1'b0; s1_we <= 1'b0; s1_addr <= '0; s1_be <= '0;
      s2_v <= 1'b0; s2_we <= 1'b0; s2_addr <= '0; s2_be <= '0;
      pend_v <= 1'b0; pend_addr <= '0; pend_be <= '0; pend_data <= '0;
      rd_v <= 1'b0; out_q <= '0;
    end else if (go) begin
      if (!adv) begin
        ctx_v  <= sel_all;
        ctx_we <= !wr_n;
        ctx_hi <= addr[ADDR_W-1:2];
        ctx_lo <= addr[1:0];
        beat   <= 2'd0;
      end else begin
        beat   <= nbeat;
      end
      s1_v <= cur_v; s1_we <= cur_we; s1_addr <= cur_addr; s1_be <= ~lane_wr_n;
      s2_v <= s1_v;  s2_we <= s1_we;  s2_addr <= s1_addr;  s2_be <= s1_be;
      pend_v    <= s2_v && s2_we;
      pend_addr <= s2_addr;
      pend_be   <= s2_be;
      pend_data <= dq_in;
      rd_v      <= s1_v && !s1_we;
      if (s1_v && !s1_we) out_q <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (go && pend_v) begin
      for (int l = 0; l < LANES; l++)
        if (pend_be[l])
          mem[pend_addr][l*LANE_W +: LANE_W] <= pend_data[l*LANE_W +: LANE_W];
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = rd_v && !out_en_n && !sleep;
endmodule

// File: rtl/noturn_sram_chk.sv
`timescale 1ns/1ps
module noturn_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          adv,
  input logic          wr_n,
  input logic          out_en_n,
  input logic          sleep,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);
  logic sel_ok;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(dq_out));

  assert_desel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && !sel_ok) ##1 !clk_en_n |=> !dq_oe);

  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && sel_ok && !wr_n) ##1 !clk_en_n |=> !dq_oe);

  assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv && sel_ok && wr_n) ##1 !clk_en_n |=> (dq_oe == (!out_en_n && !sleep)));

  assert_oe_gate_R10: assert property (@(negedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);

  assert_sleep_gate_R11: assert property (@(negedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);
endmodule

bind noturn_sram noturn_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
  .sel_b(sel_b), .sel_c_n(sel_c_n), .adv(adv), .wr_n(wr_n),
  .out_en_n(out_en_n), .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/noturn_sram_bench.sv
`timescale 1ns/1ps
module noturn_sram_bench;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, clk_en_n, sel_a_n, sel_b, sel_c_n, adv, wr_n;
  logic [LN-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic burst_lin, out_en_n, sleep, dq_oe;

  always #2 clk = !clk;

  noturn_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_noturn_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .adv(adv), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .dq_in(dq_in), .burst_lin(burst_lin),
    .out_en_n(out_en_n), .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  int p1_k, p2_k;
  logic [DW-1:0] p1_d, p2_d;
  int b_kind;
  logic [AW-3:0] b_hi;
  logic [1:0] b_st, b_beat;
  string tag;

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic drive_sel(input int selp);
    sel_a_n = (selp == 1);
    sel_b   = (selp != 2);
    sel_c_n = (selp == 3);
  endtask

  // one clock slot: drive at falling edge, check at the next falling edge
  task automatic slot(input bit en, input bit ld, input int selp, input bit wr,
                      input logic [AW-1:0] a, input logic [LN-1:0] ben);
    int kind;
    logic [DW-1:0] d, prev_out;
    logic [AW-1:0] ea;
    logic [1:0] lo;
    logic prev_oe;
    clk_en_n = !en; adv = !ld; wr_n = !wr; addr = a; lane_wr_n = ben;
    drive_sel(selp);
    dq_in = (en && p2_k == 2) ? p2_d : DW'({$urandom, $urandom});
    kind = 0; d = '0; ea = '0;
    if (en) begin
      if (ld) begin
        if (selp == 0) begin
          b_kind = wr ? 2 : 1; b_hi = a[AW-1:2]; b_st = a[1:0]; b_beat = 2'd0;
        end else b_kind = 0;
        ea = a;
      end else begin
        b_beat = b_beat + 2'd1;
        lo = burst_lin ? b_st + b_beat : b_st ^ b_beat;
        ea = {b_hi, lo};
      end
      kind = b_kind;
      if (kind == 2) begin
        d = DW'({$urandom, $urandom});
        for (int l = 0; l < LN; l++)
          if (!ben[l]) ref_mem[ea][l*LW +: LW] = d[l*LW +: LW];
      end else if (kind == 1) d = ref_mem[ea];
    end
    prev_out = dq_out; prev_oe = dq_oe;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      p2_k = p1_k; p2_d = p1_d; p1_k = kind; p1_d = d;
      if (p2_k == 1) begin
        chk(tag, dq_out, p2_d);
        chk("R2", DW'(dq_oe), DW'(!out_en_n && !sleep));
      end else if (p2_k == 2) chk("R8", DW'(dq_oe), '0);
      else chk("R7", DW'(dq_oe), '0);
    end else begin
      chk("R9", dq_out, prev_out);
      chk("R9", DW'(dq_oe), DW'(prev_oe));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1, 1, 1, 0, '0, '1);
  endtask

  task automatic read_all(input string t);
    tag = t;
    for (int a = 0; a < DEPTH; a++) slot(1, 1, 0, 0, AW'(a), LN'($urandom));
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clk_en_n = 0; adv = 0; wr_n = 1; lane_wr_n = '1; addr = '0; dq_in = '0;
    burst_lin = 1; out_en_n = 0; sleep = 0; drive_sel(1);
    p1_k = 0; p2_k = 0; p1_d = '0; p2_d = '0; b_kind = 0; b_hi = '0; b_st = '0; b_beat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8", DW'(dq_oe), '0);

    // R1 and R3: full-word fill, then read back
    tag = "R1";
    for (int a = 0; a < DEPTH; a++) slot(1, 1, 0, 1, AW'(a), '0);
    idle(2);
    read_all("R1");

    // R3: partial lane writes
    for (int a = 0; a < DEPTH; a++) slot(1, 1, 0, 1, AW'(a), LN'($urandom));
    idle(2);
    read_all("R3");

    // R4: back-to-back mixed traffic on a few addresses
    tag = "R4";
    for (int i = 0; i < 300; i++)
      slot(1, 1, 0, $urandom_range(1), AW'($urandom_range(3)), LN'($urandom));
    idle(2);

    // R5 and R6: bursts in both orders, junk selects and wr_n on advances
    tag = "R5";
    for (int o = 0; o < 2; o++) begin
      burst_lin = (o == 0);
      for (int b = 0; b < 40; b++) begin
        slot(1, 1, 0, $urandom_range(1), AW'($urandom), LN'($urandom));
        for (int k = 0; k < 3 + $urandom_range(4); k++)
          slot(1, 0, $urandom_range(3), $urandom_range(1), AW'($urandom), LN'($urandom));
      end
      idle(2);
    end
    burst_lin = 1;
    read_all("R6");

    // R7: deselects and advances after deselect
    tag = "R7";
    for (int i = 0; i < 200; i++)
      slot(1, $urandom_range(2) != 0, $urandom_range(3), $urandom_range(1),
           AW'($urandom), LN'($urandom));
    idle(2);
    read_all("R7");

    // R9: random suspends in mixed traffic
    tag = "R9";
    for (int i = 0; i < 300; i++)
      slot($urandom_range(9) < 7, $urandom_range(3) != 0, $urandom_range(4) == 4 ? 1 : 0,
           $urandom_range(1), AW'($urandom), LN'($urandom));
    idle(2);
    read_all("R9");

    // R10: asynchronous output enable
    tag = "R10";
    for (int i = 0; i < 10; i++) begin
      slot(1, 1, 0, 0, AW'($urandom), '1);
      slot(1, 1, 1, 0, '0, '1);
      out_en_n = 1; #0.4;
      chk("R10", DW'(dq_oe), '0);
      out_en_n = 0; #0.4;
      chk("R10", DW'(dq_oe), 1);
      #0.2;
    end
    idle(2);

    // R11: sleep gates outputs, contents retained
    tag = "R11";
    slot(1, 1, 0, 0, AW'(5), '1);
    slot(1, 1, 1, 0, '0, '1);
    sleep = 1; #0.4;
    chk("R11", DW'(dq_oe), '0);
    #0.6;
    for (int i = 0; i < 20; i++) slot(1, 1, 0, 0, AW'($urandom), '1);
    idle(2);
    sleep = 0;
    read_all("R11");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule